// File: doc/BRIEF.md
# Deep Idle Power-Down Sequencer

This block is the package-level controller for the deepest idle state. In that state the core supply is switched off once the core context has been put into storage that stays powered. Software asks for an idle depth. The sequencer then runs the entry steps in a fixed order, each one waiting for an acknowledge. It first tells the last-level cache to shrink. It then asks the save engine to store the context and hands over to the platform controller, which stops the core clock and blocks I/O. Last, it lowers the regulator voltage request. A break event from the platform wakes the core. The sequencer then waits for supply good, issues an internal reset, waits for PLL lock, restores the context, re-expands the cache and returns to active.

Deep entries are expensive when the core sleeps only briefly. For this reason the block measures the interval between wake events. It grants the deepest state only when each of the last few intervals reached a programmable threshold. Otherwise it grants the next shallower state, and the status output shows which depth was actually granted. A break that arrives before the platform has acknowledged entry cancels the entry without a power cycle. Every wait on an external acknowledge is bounded by a timeout, which raises an error flag and returns the block to active.

Top module: `idle_pdn_seq`

## Requirements
- R1: A deepest-state request that is allowed runs entry one step after another: cacheShrink until cacheDone, then saveReq until xferDone, then platEnter until platAck, then vidLow. At most one of cacheShrink, cacheExpand, saveReq, restoreReq and intReset is high in any cycle.
- R2: In the deep state, platEnter and vidLow stay high until breakEvt. No other input causes a wake.
- R3: Exit after a breakEvt in the deep state drops vidLow and platEnter and waits for pwrGood. It then raises intReset for exactly one cycle, waits for pllLock, raises restoreReq until xferDone and cacheExpand until cacheDone, and then returns to active.
- R4: A request for depth 3 is granted as depth 2 unless each of the last HIST_N recorded wake intervals was at least demoteThr cycles. After reset no interval is recorded, so the request is demoted.
- R5: A wake interval is the number of cycles from reset, or from the previous wake, to the current wake. It saturates at the counter maximum. A wake is a breakEvt accepted in a shallow state, in the deep state, or during entry.
- R6: A breakEvt in the cacheShrink, saveReq or platEnter phase aborts entry. The next cycle shows cacheExpand, with no intReset and no restoreReq. After cacheDone the block is active.
- R7: If an acknowledge wait lasts TO_LIM+1 cycles without the awaited input or a break, errFlag is set and the block returns to active with grantedDepth 0. The deep and shallow states have no timeout.
- R8: errFlag stays set until the next idle request that is accepted, and that request clears it.
- R9: grantedDepth reports 0 while active and the granted depth (1, 2 or 3) from the cycle after acceptance until the block is active again.
- R10: Requests for depth 1 or 2 are granted directly and end on breakEvt. A request for depth 0 and a breakEvt while active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleReq | input | 1 | Idle request strobe |
| idleDepth | input | 2 | Requested depth, 0 none, 3 deepest |
| demoteThr | input | CNT_W | Minimum wake interval for deep entry, in cycles |
| cacheDone | input | 1 | Cache shrink or expand complete |
| xferDone | input | 1 | Context save or restore complete |
| platAck | input | 1 | Platform has stopped the clock and blocked I/O |
| breakEvt | input | 1 | Platform break event (wake) |
| pwrGood | input | 1 | Core supply at level |
| pllLock | input | 1 | PLL locked |
| cacheShrink | output | 1 | Shrink command to the cache |
| cacheExpand | output | 1 | Expand command to the cache |
| saveReq | output | 1 | Context save command |
| restoreReq | output | 1 | Context restore command |
| platEnter | output | 1 | Deep-state handshake to the platform |
| vidLow | output | 1 | Request a retention-level voltage ID |
| intReset | output | 1 | One-cycle internal reset |
| grantedDepth | output | 2 | Idle depth actually granted |
| errFlag | output | 1 | Acknowledge timeout occurred |

## Verification
The hardest situations to reach are demotion of a deep request and a break event in the middle of entry. Demotion depends on the history of past wake intervals and not on the current inputs. The bench therefore builds that history on purpose: it runs shallow idle periods of known length, some longer and some shorter than the threshold, before each deep request. To land a break inside a chosen entry phase, the bench waits until the command of that phase shows at the ports and asserts breakEvt in that cycle. Small responder processes stand in for the cache, the save engine, the platform, the regulator and the PLL.

// File: rtl/idle_pdn_pkg.sv
package idle_pdn_pkg;
  typedef enum logic [3:0] {
    S_ACT, S_SHAL, S_SHRINK, S_SAVE, S_PLAT, S_DEEP,
    S_WAKE, S_RST, S_PLL, S_REST, S_EXP
  } seq_st_t;

  typedef struct packed {
    logic tmrClr;
    logic wakeEvt;
  } seq_strb_t;

  localparam logic [1:0] DEPTH_DEEP   = 2'd3;
  localparam logic [1:0] DEPTH_DEMOTE = 2'd2;
endpackage

// File: rtl/idle_pdn_dp.sv
module idle_pdn_dp
  import idle_pdn_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HIST_N = 2,
  parameter int TO_LIM = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strb_t        strb,
  input  logic [CNT_W-1:0] thr,
  output logic             timeout,
  output logic             deepOk
);
  localparam int TMR_W = $clog2(TO_LIM + 1);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(TO_LIM);

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] ivCnt;
  logic [HIST_N-1:0] hist;

  // time spent in the current state
  always_ff @(posedge clk) begin
    if (!rstN || strb.tmrClr) tmr <= '0;
    else if (tmr != TMR_END)  tmr <= tmr + 1'b1;
  end
  assign timeout = (tmr == TMR_END);

  // wake interval counter and pass/fail history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivCnt <= '0;
      hist  <= '0;
    end else if (strb.wakeEvt) begin
      ivCnt <= '0;
      if (HIST_N == 1) hist <= HIST_N'(ivCnt >= thr);
      else             hist <= {hist[HIST_N-2:0], (ivCnt >= thr)};
    end else if (ivCnt != {CNT_W{1'b1}}) begin
      ivCnt <= ivCnt + 1'b1;
    end
  end
  assign deepOk = &hist;

  // R7
  tmr_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.tmrClr) |-> !timeout);
  // R4
  short_demote_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wakeEvt && (ivCnt < thr)) |=> !deepOk);
endmodule

// File: rtl/idle_pdn_ctrl.sv
module idle_pdn_ctrl
  import idle_pdn_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      idleReq,
  input  logic [1:0] idleDepth,
  input  logic      cacheDone,
  input  logic      xferDone,
  input  logic      platAck,
  input  logic      breakEvt,
  input  logic      pwrGood,
  input  logic      pllLock,
  input  logic      timeout,
  input  logic      deepOk,
  output seq_strb_t strb,
  output logic      cacheShrink,
  output logic      cacheExpand,
  output logic      saveReq,
  output logic      restoreReq,
  output logic      platEnter,
  output logic      vidLow,
  output logic      intReset,
  output logic [1:0] grantedDepth,
  output logic      errFlag
);
  seq_st_t st, nxt;
  logic setErr, wake;
  logic [1:0] grantNxt;

  always_comb begin
    nxt = st;
    setErr = 1'b0;
    wake = 1'b0;
    grantNxt = grantedDepth;
    unique case (st)
      S_ACT: if (idleReq && idleDepth != 2'd0) begin
        if (idleDepth == DEPTH_DEEP && deepOk) begin
          nxt = S_SHRINK; grantNxt = DEPTH_DEEP;
        end else begin
          nxt = S_SHAL;
          grantNxt = (idleDepth == DEPTH_DEEP) ? DEPTH_DEMOTE : idleDepth;
        end
      end
      S_SHAL: if (breakEvt) begin wake = 1'b1; nxt = S_ACT; end
      S_SHRINK: begin
        if (breakEvt)       begin wake = 1'b1; nxt = S_EXP; end
        else if (cacheDone) nxt = S_SAVE;
        else if (timeout)   begin setErr = 1'b1; nxt = S_ACT; end
      end
      S_SAVE: begin
        if (breakEvt)      begin wake = 1'b1; nxt = S_EXP; end
        else if (xferDone) nxt = S_PLAT;
        else if (timeout)  begin setErr = 1'b1; nxt = S_ACT; end
      end
      S_PLAT: begin
        if (breakEvt)     begin wake = 1'b1; nxt = S_EXP; end
        else if (platAck) nxt = S_DEEP;
        else if (timeout) begin setErr = 1'b1; nxt = S_ACT; end
      end
      S_DEEP: if (breakEvt) begin wake = 1'b1; nxt = S_WAKE; end
      S_WAKE: begin
        if (pwrGood)      nxt = S_RST;
        else if (timeout) begin setErr = 1'b1; nxt = S_ACT; end
      end
      S_RST: nxt = S_PLL;
      S_PLL: begin
        if (pllLock)      nxt = S_REST;
        else if (timeout) begin setErr = 1'b1; nxt = S_ACT; end
      end
      S_REST: begin
        if (xferDone)     nxt = S_EXP;
        else if (timeout) begin setErr = 1'b1; nxt = S_ACT; end
      end
      S_EXP: begin
        if (cacheDone)    nxt = S_ACT;
        else if (timeout) begin setErr = 1'b1; nxt = S_ACT; end
      end
      default: nxt = S_ACT;
    endcase
    if (nxt == S_ACT) grantNxt = 2'd0;
  end

  assign strb.tmrClr  = (nxt != st);
  assign strb.wakeEvt = wake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_ACT;
      grantedDepth <= 2'd0;
      errFlag <= 1'b0;
    end else begin
      st <= nxt;
      grantedDepth <= grantNxt;
      if (setErr) errFlag <= 1'b1;
      else if (st == S_ACT && nxt != S_ACT) errFlag <= 1'b0;
    end
  end

  assign cacheShrink = (st == S_SHRINK);
  assign saveReq     = (st == S_SAVE);
  assign platEnter   = (st == S_PLAT) || (st == S_DEEP);
  assign vidLow      = (st == S_DEEP);
  assign intReset    = (st == S_RST);
  assign restoreReq  = (st == S_REST);
  assign cacheExpand = (st == S_EXP);

  // R1
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cacheShrink, cacheExpand, saveReq, restoreReq, intReset}));
  // R3
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReset |=> !intReset);
  // R2
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    vidLow |-> (platEnter && grantedDepth == DEPTH_DEEP));
  // R7
  err_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (grantedDepth == 2'd0));
endmodule

// File: rtl/idle_pdn_seq.sv
module idle_pdn_seq
  import idle_pdn_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HIST_N = 2,
  parameter int TO_LIM = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleReq,
  input  logic [1:0]       idleDepth,
  input  logic [CNT_W-1:0] demoteThr,
  input  logic             cacheDone,
  input  logic             xferDone,
  input  logic             platAck,
  input  logic             breakEvt,
  input  logic             pwrGood,
  input  logic             pllLock,
  output logic             cacheShrink,
  output logic             cacheExpand,
  output logic             saveReq,
  output logic             restoreReq,
  output logic             platEnter,
  output logic             vidLow,
  output logic             intReset,
  output logic [1:0]       grantedDepth,
  output logic             errFlag
);
  seq_strb_t strb;
  logic timeout, deepOk;

  idle_pdn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .idleDepth(idleDepth),
    .cacheDone(cacheDone), .xferDone(xferDone), .platAck(platAck),
    .breakEvt(breakEvt), .pwrGood(pwrGood), .pllLock(pllLock),
    .timeout(timeout), .deepOk(deepOk), .strb(strb),
    .cacheShrink(cacheShrink), .cacheExpand(cacheExpand),
    .saveReq(saveReq), .restoreReq(restoreReq), .platEnter(platEnter),
    .vidLow(vidLow), .intReset(intReset), .grantedDepth(grantedDepth),
    .errFlag(errFlag)
  );

  idle_pdn_dp #(.CNT_W(CNT_W), .HIST_N(HIST_N), .TO_LIM(TO_LIM)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .thr(demoteThr),
    .timeout(timeout), .deepOk(deepOk)
  );
endmodule

// File: tb/idle_pdn_seq_bench.sv
module idle_pdn_seq_bench;
  localparam int CW = 16;
  localparam int HN = 2;
  localparam int TL = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic idleReq = 1'b0, breakEvt = 1'b0;
  logic [1:0] idleDepth = 2'd0;
  logic [CW-1:0] demoteThr = 16'd20;
  logic cacheDone = 1'b0, xferDone = 1'b0, platAck = 1'b0;
  logic pwrGood = 1'b1, pllLock = 1'b1;
  logic cacheShrink, cacheExpand, saveReq, restoreReq, platEnter, vidLow, intReset, errFlag;
  logic [1:0] grantedDepth;

  int tests = 0, fails = 0;
  bit cacheOn = 1'b1;

  always #2.5 clk = ~clk;

  idle_pdn_seq #(.CNT_W(CW), .HIST_N(HN), .TO_LIM(TL)) u_idle_pdn_seq (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .idleDepth(idleDepth),
    .demoteThr(demoteThr), .cacheDone(cacheDone), .xferDone(xferDone),
    .platAck(platAck), .breakEvt(breakEvt), .pwrGood(pwrGood), .pllLock(pllLock),
    .cacheShrink(cacheShrink), .cacheExpand(cacheExpand), .saveReq(saveReq),
    .restoreReq(restoreReq), .platEnter(platEnter), .vidLow(vidLow),
    .intReset(intReset), .grantedDepth(grantedDepth), .errFlag(errFlag)
  );

  task automatic check(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- responders ----------------
  int cc = 0, xc = 0, pc = 0, pgc = 0, plc = 0;
  logic [1:0] cPrev = 2'b00, xPrev = 2'b00;
  always @(posedge clk) begin
    #1;
    if ({cacheShrink, cacheExpand} != cPrev) cc = 0; else cc++;
    cacheDone = cacheOn && ({cacheShrink, cacheExpand} != 2'b00) && cc == 2;
    cPrev = {cacheShrink, cacheExpand};
    if ({saveReq, restoreReq} != xPrev) xc = 0; else xc++;
    xferDone = ({saveReq, restoreReq} != 2'b00) && xc == 3;
    xPrev = {saveReq, restoreReq};
    if (platEnter) pc++; else pc = 0;
    platAck = (pc >= 2);
    if (vidLow) begin pgc = 0; pwrGood = 1'b0; end
    else if (!pwrGood) begin pgc++; if (pgc >= 4) pwrGood = 1'b1; end
    if (intReset) begin plc = 0; pllLock = 1'b0; end
    else if (!pllLock) begin plc++; if (plc >= 3) pllLock = 1'b1; end
  end

  // ---------------- behavioural reference ----------------
  // phases: 0 active,1 shallow,2 shrink,3 save,4 plat,5 deep,6 wake,7 reset,8 pll,9 restore,10 expand
  int mPh = 0, mGrant = 0, mErr = 0, mAge = 0, mIval = 0;
  bit mHist[$];

  always @(posedge clk) begin
    int np;
    bit w, e, ok;
    if (!rstN) begin
      mPh = 0; mGrant = 0; mErr = 0; mAge = 0; mIval = 0; mHist.delete();
    end else begin
      np = mPh; w = 0; e = 0;
      ok = (mHist.size() == HN);
      foreach (mHist[i]) if (!mHist[i]) ok = 0;
      case (mPh)
        0: if (idleReq && idleDepth != 0) begin
             if (idleDepth == 3 && ok) begin np = 2; mGrant = 3; end
             else begin np = 1; mGrant = (idleDepth == 3) ? 2 : idleDepth; end
             mErr = 0;
           end
        1: if (breakEvt) begin w = 1; np = 0; end
        2, 3, 4: begin
             if (breakEvt) begin w = 1; np = 10; end
             else if ((mPh == 2 && cacheDone) || (mPh == 3 && xferDone) || (mPh == 4 && platAck)) np = mPh + 1;
             else if (mAge >= TL) e = 1;
           end
        5: if (breakEvt) begin w = 1; np = 6; end
        6: if (pwrGood) np = 7; else if (mAge >= TL) e = 1;
        7: np = 8;
        8: if (pllLock) np = 9; else if (mAge >= TL) e = 1;
        9: if (xferDone) np = 10; else if (mAge >= TL) e = 1;
        10: if (cacheDone) np = 0; else if (mAge >= TL) e = 1;
        default: np = 0;
      endcase
      if (e) begin np = 0; mErr = 1; end
      if (np == 0) mGrant = 0;
      if (w) begin
        mHist.push_back(mIval >= demoteThr);
        if (mHist.size() > HN) void'(mHist.pop_front());
        mIval = 0;
      end else if (mIval < 65535) mIval++;
      if (np != mPh) mAge = 0; else mAge++;
      mPh = np;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(cacheShrink, mPh == 2, "R1 cacheShrink");
      check(saveReq, mPh == 3, "R1 saveReq");
      check(platEnter, mPh == 4 || mPh == 5, "R2 platEnter");
      check(vidLow, mPh == 5, "R2 vidLow");
      check(intReset, mPh == 7, "R3 intReset");
      check(restoreReq, mPh == 9, "R3 restoreReq");
      check(cacheExpand, mPh == 10, "R6 cacheExpand");
      check(grantedDepth, mGrant, "R9 grantedDepth");
      check(errFlag, mErr, "R7 errFlag");
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic request(input int d);
    idleReq = 1'b1; idleDepth = 2'(d); step(); idleReq = 1'b0; idleDepth = 2'd0;
  endtask

  task automatic wake();
    breakEvt = 1'b1; step(); breakEvt = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 300 && grantedDepth != 2'd0; i++) step();
  endtask

  task automatic shallowCycle(input int hold);
    request(1); step(hold); wake(); settle();
  endtask

  initial begin
    step(3);
    check(grantedDepth, 0, "R9 reset depth");
    check({cacheShrink, saveReq, platEnter, vidLow, intReset, errFlag}, 0, "R1 reset outputs");
    rstN = 1'b1;
    step(2);

    request(0); // R10 depth 0 ignored
    check(grantedDepth, 0, "R10 depth0 ignored");
    wake();     // R10 break in active ignored
    check(grantedDepth, 0, "R10 break while active");

    step(30);
    request(1);
    check(grantedDepth, 1, "R10 shallow granted");
    step(30); wake();
    check(grantedDepth, 0, "R10 shallow exit");

    request(3); // one long interval only
    check(grantedDepth, 2, "R4 demoted with short history");
    step(30); wake();

    request(3); // two long intervals recorded
    check(grantedDepth, 3, "R4 deep allowed");
    check(cacheShrink, 1, "R1 shrink first");
    for (int i = 0; i < 100 && !vidLow; i++) step();
    check(vidLow, 1, "R1 reached deep");
    step(10);
    check(vidLow, 1, "R2 deep held");
    wake();
    check(vidLow, 0, "R3 voltage raised on wake");
    settle();
    check(grantedDepth, 0, "R3 returned active");

    shallowCycle(2); // short interval R5
    request(3);
    check(grantedDepth, 2, "R5 short interval demotes");
    step(30); wake();

    shallowCycle(30);
    shallowCycle(30);
    request(3);
    for (int i = 0; i < 50 && !saveReq; i++) step();
    wake(); // R6 abort during save
    check(cacheExpand, 1, "R6 abort expands");
    check(restoreReq, 0, "R6 no restore");
    check(intReset, 0, "R6 no reset");
    settle();
    check(grantedDepth, 0, "R6 active after abort");

    shallowCycle(30);
    shallowCycle(30);
    cacheOn = 1'b0;
    request(3);
    for (int i = 0; i < 200 && !errFlag; i++) step();
    check(errFlag, 1, "R7 timeout error");
    check(grantedDepth, 0, "R7 active after timeout");
    cacheOn = 1'b1;
    step(3);
    check(errFlag, 1, "R8 error held");
    request(1);
    check(errFlag, 0, "R8 cleared by request");
    step(5); wake();
    step(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule